// File: doc/BRIEF.md
# Address Permission Filter

This block decides whether a packet's address may use a given network service. A table of entries holds permitted addresses. Each entry has an address, a care mask and a 4-bit permission word. A request gives a 32-bit address and a 2-bit service code. All valid entries compare against the address in parallel. Only the bit positions set in an entry's care mask take part in that comparison, so an entry can stand for a whole prefix.

When more than one entry matches, the most specific entry wins. If no entry matches, the request is blocked. If an entry matches, the permission bit for the requested service decides the result. This lets one address be allowed for mail but refused for remote terminal use.

Software or a control engine loads the table through a write port, one entry per cycle. Each request gets one response on a fixed schedule, so a packet pipeline can line up verdicts with packets without a handshake.

Top module: `addr_perm_filter`

## Requirements
- R1: After a synchronous reset, `rsp_valid` is low and every table entry is invalid, so the first lookups all miss.
- R2: A request accepted with `req_valid` high in cycle t produces exactly one response with `rsp_valid` high in cycle t+2. Back-to-back requests are accepted every cycle.
- R3: A request that matches no valid entry returns `rsp_hit`=0, `rsp_permit`=0 and `rsp_idx`=0.
- R4: An entry matches when every address bit whose care-mask bit is 1 equals the stored bit. Bits whose mask bit is 0 are ignored, so an all-zero mask matches any address.
- R5: `rsp_permit` is 1 only on a hit whose selected entry has its permission bit set at position `req_svc`. The service codes are: 0 mail, 1 web, 2 file transfer, 3 remote terminal.
- R6: Among matching entries, the one with the most care-mask bits set is selected, and its index is returned on `rsp_idx`.
- R7: Among matching entries with equal care-bit counts, the lowest index is selected.
- R8: When `wr_en` is high, entry `wr_idx` is loaded with address, mask, permission word and valid flag. A request accepted in the same cycle still sees the old contents. Requests accepted from the next cycle on see the new contents.
- R9: An entry written with `wr_valid`=0 never matches.
- R10: While `rsp_valid` is low, `rsp_hit`, `rsp_permit` and `rsp_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load one table entry this cycle |
| wr_idx | input | IDX_W | Entry being loaded |
| wr_addr | input | ADDR_W | Stored address |
| wr_mask | input | ADDR_W | Care mask (1 = bit compared) |
| wr_perm | input | 4 | Permission word, bit n enables service code n |
| wr_valid | input | 1 | Valid flag for the loaded entry |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Address to look up |
| req_svc | input | 2 | Requested service code |
| rsp_valid | output | 1 | Response strobe, two cycles after the request |
| rsp_hit | output | 1 | Some valid entry matched |
| rsp_idx | output | IDX_W | Selected entry index (0 on a miss) |
| rsp_permit | output | 1 | Request permitted |

## Verification
Every result is due exactly two cycles after its request is presented. The bench driver stamps each expected item with the cycle count at which `rsp_valid` must appear: the count at presentation plus two. The monitor samples on the falling edge and checks both the stamp and the content. Writes issued in the same cycle as a request are applied to the bench's model only after that request's expectation has been computed, which matches R8's same-cycle rule. Idle cycles are checked for all-zero outputs.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;

    localparam int PERM_W = 4;
    localparam int SVC_W  = 2;

    typedef enum logic [SVC_W-1:0] {
        SVC_MAIL = 2'd0,
        SVC_WEB  = 2'd1,
        SVC_FILE = 2'd2,
        SVC_TERM = 2'd3
    } svc_e;

    // Registered result of the selection stage
    typedef struct packed {
        logic valid;
        logic hit;
        logic permit;
    } verdict_t;

    // Number of ones in a mask of up to 64 bits
    function automatic int unsigned count_ones(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            n += {31'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/filter_entry_table.sv
module filter_entry_table
    import addr_filter_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [ADDR_W-1:0]            wr_mask,
    input  logic [PERM_W-1:0]            wr_perm,
    input  logic                         wr_valid,
    input  logic [ADDR_W-1:0]            key_addr,
    input  logic [SVC_W-1:0]             key_svc,
    output logic [DEPTH-1:0]             match_o,
    output logic [DEPTH-1:0]             perm_bit_o,
    output logic [DEPTH-1:0][CNT_W-1:0]  care_cnt_o
);

    // Care-bit count of the incoming mask, computed once at write time
    logic [CNT_W-1:0] wr_cnt;
    assign wr_cnt = CNT_W'(count_ones(64'(wr_mask)));

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic              vld_q;
        logic [ADDR_W-1:0] addr_q;
        logic [ADDR_W-1:0] mask_q;
        logic [PERM_W-1:0] perm_q;
        logic [CNT_W-1:0]  cnt_q;
        logic              sel;

        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q  <= 1'b0;
                addr_q <= '0;
                mask_q <= '0;
                perm_q <= '0;
                cnt_q  <= '0;
            end else if (sel) begin
                vld_q  <= wr_valid;
                addr_q <= wr_addr;
                mask_q <= wr_mask;
                perm_q <= wr_perm;
                cnt_q  <= wr_cnt;
            end
        end

        assign match_o[e]    = vld_q && (((key_addr ^ addr_q) & mask_q) == '0);
        assign perm_bit_o[e] = perm_q[key_svc];
        assign care_cnt_o[e] = cnt_q;
    end

endmodule

// File: rtl/filter_best_pick.sv
module filter_best_pick #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 6
) (
    input  logic [DEPTH-1:0]            match_i,
    input  logic [DEPTH-1:0][CNT_W-1:0] cnt_i,
    output logic                        found_o,
    output logic [IDX_W-1:0]            idx_o
);

    logic [CNT_W-1:0] best;

    // Strictly greater replaces, so equal counts keep the lower index
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match_i[i] && (!found_o || cnt_i[i] > best)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                best    = cnt_i[i];
            end
        end
    end

endmodule

// File: rtl/addr_perm_filter.sv
module addr_perm_filter
    import addr_filter_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] wr_mask,
    input  logic [3:0]        wr_perm,
    input  logic              wr_valid,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_svc,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic              rsp_permit
);

    logic [DEPTH-1:0]            tbl_match;
    logic [DEPTH-1:0]            tbl_perm;
    logic [DEPTH-1:0][CNT_W-1:0] tbl_cnt;

    filter_entry_table #(
        .ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_addr    (wr_addr),
        .wr_mask    (wr_mask),
        .wr_perm    (wr_perm),
        .wr_valid   (wr_valid),
        .key_addr   (req_addr),
        .key_svc    (req_svc),
        .match_o    (tbl_match),
        .perm_bit_o (tbl_perm),
        .care_cnt_o (tbl_cnt)
    );

    // Stage 1: snapshot of compare results, so later writes cannot disturb
    logic                        s1_vld;
    logic [DEPTH-1:0]            s1_match;
    logic [DEPTH-1:0]            s1_perm;
    logic [DEPTH-1:0][CNT_W-1:0] s1_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld   <= 1'b0;
            s1_match <= '0;
            s1_perm  <= '0;
            s1_cnt   <= '0;
        end else begin
            s1_vld   <= req_valid;
            s1_match <= req_valid ? tbl_match : '0;
            s1_perm  <= tbl_perm;
            s1_cnt   <= tbl_cnt;
        end
    end

    // Stage 2: choose most specific entry and register the verdict
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;

    filter_best_pick #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_pick (
        .match_i (s1_match),
        .cnt_i   (s1_cnt),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    verdict_t         nxt_v, out_v;
    logic [IDX_W-1:0] nxt_idx, out_idx;

    always_comb begin
        nxt_v.valid  = s1_vld;
        nxt_v.hit    = s1_vld && pick_found;
        nxt_v.permit = nxt_v.hit && s1_perm[pick_idx];
        nxt_idx      = nxt_v.hit ? pick_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v   <= '0;
            out_idx <= '0;
        end else begin
            out_v   <= nxt_v;
            out_idx <= nxt_idx;
        end
    end

    assign rsp_valid  = out_v.valid;
    assign rsp_hit    = out_v.hit;
    assign rsp_permit = out_v.permit;
    assign rsp_idx    = out_idx;

endmodule

// File: rtl/addr_perm_filter_chk.sv
module addr_perm_filter_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_permit,
    input logic [IDX_W-1:0] rsp_idx
);

    logic       rst_q = 1'b0;
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst_q |-> !rsp_valid);

    assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (rsp_valid == $past(req_valid, 2)));

    assert_miss_index_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_idx == '0 && !rsp_permit));

    assert_permit_needs_hit_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_permit |-> rsp_hit);

    assert_idle_outputs_R10: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_permit && rsp_idx == '0));

endmodule

bind addr_perm_filter addr_perm_filter_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_permit (rsp_permit),
    .rsp_idx    (rsp_idx)
);

// File: tb/addr_perm_filter_bench.sv
module addr_perm_filter_bench;

    localparam int ADDR_W = 32;
    localparam int DEPTH  = 16;
    localparam int IDX_W  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [ADDR_W-1:0] wr_mask = '0;
    logic [3:0]        wr_perm = '0;
    logic              wr_valid = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_svc = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [IDX_W-1:0]  rsp_idx;
    logic              rsp_permit;

    addr_perm_filter u_addr_perm_filter (.*);

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        int               due;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             permit;
        string            tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference table
    logic              m_vld  [DEPTH];
    logic [ADDR_W-1:0] m_addr [DEPTH];
    logic [ADDR_W-1:0] m_mask [DEPTH];
    logic [3:0]        m_perm [DEPTH];

    task automatic step(input bit do_wr, input int widx, input logic [31:0] waddr,
                        input logic [31:0] wmask, input logic [3:0] wperm, input bit wv,
                        input bit do_req, input logic [31:0] raddr, input logic [1:0] rsvc,
                        input string tag);
        exp_t e;
        int   best;
        @(negedge clk);
        if (do_req) begin
            e.due = cyc + 2; e.hit = 1'b0; e.idx = '0; e.permit = 1'b0; e.tag = tag;
            best = -1;
            for (int i = 0; i < DEPTH; i++) begin
                if (m_vld[i] && (((raddr ^ m_addr[i]) & m_mask[i]) == '0)
                    && $countones(m_mask[i]) > best) begin
                    best  = $countones(m_mask[i]);
                    e.hit = 1'b1;
                    e.idx = IDX_W'(i);
                end
            end
            if (e.hit) e.permit = m_perm[e.idx][rsvc];
            exp_q.push_back(e);
        end
        if (do_wr) begin
            m_vld[widx] = wv; m_addr[widx] = waddr;
            m_mask[widx] = wmask; m_perm[widx] = wperm;
        end
        wr_en = do_wr; wr_idx = IDX_W'(widx); wr_addr = waddr;
        wr_mask = wmask; wr_perm = wperm; wr_valid = wv;
        req_valid = do_req; req_addr = raddr; req_svc = rsvc;
    endtask

    task automatic wr(input int idx, input logic [31:0] a, input logic [31:0] m,
                      input logic [3:0] p, input bit v);
        step(1, idx, a, m, p, v, 0, '0, '0, "");
    endtask

    task automatic rq(input logic [31:0] a, input logic [1:0] s, input string tag);
        step(0, 0, '0, '0, '0, 0, 1, a, s, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, '0, '0, 0, 0, '0, '0, "");
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rsp_valid) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R2: unexpected response act valid=1 exp valid=0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (cyc != e.due) begin
                        n_bad++;
                        $display("FAIL R2: response cycle act %0d exp %0d", cyc, e.due);
                    end
                    if (rsp_hit !== e.hit || rsp_idx !== e.idx || rsp_permit !== e.permit) begin
                        n_bad++;
                        $display("FAIL %s: hit/idx/permit act %0b/%0d/%0b exp %0b/%0d/%0b",
                                 e.tag, rsp_hit, rsp_idx, rsp_permit, e.hit, e.idx, e.permit);
                    end
                end
            end else begin
                n_chk++;
                if (rsp_hit !== 1'b0 || rsp_permit !== 1'b0 || rsp_idx !== '0) begin
                    n_bad++;
                    $display("FAIL R10: idle hit/idx/permit act %0b/%0d/%0b exp 0/0/0",
                             rsp_hit, rsp_idx, rsp_permit);
                end
                if (exp_q.size() != 0 && cyc >= exp_q[0].due) begin
                    n_bad++;
                    $display("FAIL R2: missing response act valid=0 exp valid=1 (%s)", exp_q[0].tag);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    task automatic finish_run;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run act hung exp finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_vld[i] = 1'b0; m_addr[i] = '0; m_mask[i] = '0; m_perm[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: rsp_valid after reset act %0b exp 0", rsp_valid);
        end
        // R1 / R3: empty table blocks everything
        rq(32'h0A01_0203, 2'd0, "R1");
        rq(32'hC0A8_0001, 2'd3, "R3");
        // R8: write and lookup in same cycle sees old table, next sees new
        step(1, 0, 32'h0A01_0203, 32'hFFFF_FFFF, 4'b0011, 1,
             1, 32'h0A01_0203, 2'd0, "R8");
        rq(32'h0A01_0203, 2'd0, "R8");
        // R5: per-service permission (mail=0, web=1, file=2, term=3)
        rq(32'h0A01_0203, 2'd1, "R5");
        rq(32'h0A01_0203, 2'd2, "R5");
        rq(32'h0A01_0203, 2'd3, "R5");
        // R4: prefix /16
        wr(1, 32'h0A01_0000, 32'hFFFF_0000, 4'b0100, 1);
        rq(32'h0A01_0909, 2'd2, "R4");
        rq(32'h0A02_0909, 2'd2, "R4");
        // R6: longer mask wins even though it denies the service
        rq(32'h0A01_0203, 2'd2, "R6");
        // R7: equal /8 entries, lower index wins
        wr(3, 32'h0A00_0000, 32'hFF00_0000, 4'b0010, 1);
        wr(2, 32'h0A00_0000, 32'hFF00_0000, 4'b1000, 1);
        rq(32'h0AC8_0000, 2'd3, "R7");
        rq(32'h0AC8_0000, 2'd1, "R7");
        // R9: invalidated entry no longer matches
        wr(2, 32'h0A00_0000, 32'hFF00_0000, 4'b1000, 0);
        rq(32'h0AC8_0000, 2'd1, "R9");
        rq(32'h0AC8_0000, 2'd3, "R9");
        // R4: all-zero mask matches any address at lowest specificity
        wr(5, 32'h1234_5678, 32'h0000_0000, 4'b1000, 1);
        rq(32'hC0A8_0001, 2'd3, "R4");
        rq(32'h0A01_0909, 2'd2, "R6");
        idle(3);
        // R2: back-to-back stream of mixed requests
        for (int k = 0; k < 12; k++)
            rq(32'h0A01_0000 + 32'(k * 32'h0001_0101), 2'(k), "R2");
        idle(6);
        // R1: reset clears the table
        @(negedge clk); rst = 1'b1;
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
        exp_q.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rq(32'h0A01_0203, 2'd0, "R1");
        rq(32'hC0A8_0001, 2'd3, "R1");
        idle(5);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: pending responses act %0d exp 0", exp_q.size());
        end
        finish_run();
    end

endmodule